// File: doc/BRIEF.md
# Sector Error-Correction Sequencer

This block steers error handling for one buffered CD-ROM data sector. When a sector start arrives, it captures the detected sector kind, the configured decode mode and the round count. From these it decides whether an EDC check applies and whether ECC correction applies. It then calls four external engines in order: a CRC check engine (EDC), a syndrome engine that reports whether the P and Q syndromes are zero, a P-pass corrector and a Q-pass corrector. Each call is a one-cycle start strobe followed by a one-cycle done pulse from the engine.

The sequence always begins with an EDC check. If correction applies, a syndrome check follows, and correction rounds run only while the judged syndromes are non-zero. Every round is followed by a fresh syndrome check. A second EDC check closes the sequence. The block ends with a one-cycle done pulse. It keeps the EDC results, the final P and Q syndrome results and a sticky ECC-failure bit, and it raises an error interrupt when the sector cannot be corrected. A sector flagged as short is treated as uncorrectable at once.

Top module: `sector_fix_seq`

## Requirements
- R1: After reset, every start strobe, `sec_done`, `err_irq` and all five status bits are 0.
- R2: Sector kind codes are 0 = mode 0, 1 = mode 1, 2 = mode 2 without the extended header, 3 = mode 2 form 1, 4 = mode 2 form 2, and 5..7 behave like 0. Kinds 0, 2 and 5..7 call no engine, and `sec_done` rises one cycle after the start is sampled.
- R3: A kind-4 sector runs the EDC check only, never the syndrome engine or a correction pass, whatever the mode.
- R4: Mode codes are 0 = nothing, 1 = EDC only, 2 = P, 3 = Q, 4 = P then Q, 5 = Q then P, and 6..7 = nothing. Modes 0, 6 and 7 call no engine. Mode 1 calls only one EDC check.
- R5: When correction applies, one EDC check runs before the first syndrome check and one runs after the last one. `st_edc_pre_bad` and `st_edc_post_bad` hold the inverse of the respective match result.
- R6: The first action of correction is a syndrome check. When the judged syndromes are zero (P for mode 2, Q for mode 3, both for modes 4 and 5), no pass runs.
- R7: A round runs the passes in mode order (P, Q, P then Q, or Q then P) and is followed by a syndrome check. Each start strobe comes one cycle after the previous done is sampled.
- R8: Modes 2 and 3 run at most one round. Modes 4 and 5 run at most `cfg_rounds` rounds, where 0 counts as 1, and stop early once the judged syndromes are zero.
- R9: If the judged syndromes are still non-zero after the last allowed round, `st_ecc_fail` is set and `err_irq` pulses together with `sec_done`.
- R10: A sector start with `sec_short` high calls no engine. It sets `st_ecc_fail` and pulses `err_irq` with `sec_done` one cycle later.
- R11: `st_p_syn_nz` and `st_q_syn_nz` show the last syndrome result (1 = non-zero). They stay 0 when correction does not apply.
- R12: `sec_done` is a single-cycle pulse one cycle after the final engine done is sampled. At most one start strobe is high at a time. The status bits hold until the next sector start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_start | input | 1 | Begin handling a sector (sampled when idle) |
| sec_kind | input | 3 | Detected sector mode/form code |
| sec_short | input | 1 | Sector was detected as short |
| cfg_mode | input | 3 | Decode mode code |
| cfg_rounds | input | 2 | Round limit for the combined modes |
| edc_start | output | 1 | Start strobe to the EDC engine |
| edc_done | input | 1 | EDC engine finished |
| edc_match | input | 1 | EDC result matched (valid with done) |
| syn_start | output | 1 | Start strobe to the syndrome engine |
| syn_done | input | 1 | Syndrome engine finished |
| syn_p_zero | input | 1 | P syndrome is zero (valid with done) |
| syn_q_zero | input | 1 | Q syndrome is zero (valid with done) |
| p_start | output | 1 | Start strobe to the P-pass corrector |
| p_done | input | 1 | P pass finished |
| q_start | output | 1 | Start strobe to the Q-pass corrector |
| q_done | input | 1 | Q pass finished |
| sec_done | output | 1 | Sector finished, one-cycle pulse |
| err_irq | output | 1 | Uncorrectable-sector interrupt pulse |
| st_edc_pre_bad | output | 1 | EDC mismatch before correction |
| st_edc_post_bad | output | 1 | EDC mismatch after correction |
| st_p_syn_nz | output | 1 | Final P syndrome non-zero |
| st_q_syn_nz | output | 1 | Final Q syndrome non-zero |
| st_ecc_fail | output | 1 | Sticky ECC failure flag |

## Verification
The assertions assume that `sec_start` arrives only while the block is idle and not in the cycle right after a done pulse. They also assume that each engine raises its done for one cycle, only after its own start, with results valid in that cycle. The bench keeps to these limits. It starts a new sector only after it has seen `sec_done` and one more quiet cycle, and it answers exactly the engine whose strobe it expected, after a chosen latency of one to three cycles. The bench's sector model counts down the outstanding P and Q errors on each pass, so the syndrome answers it returns always match the passes that have run.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    localparam int KIND_W = 3;
    localparam int MODE_W = 3;
    localparam int ITER_W = 2;
    localparam int N_OPS  = 4;

    localparam logic [KIND_W-1:0] KIND_M1    = 3'd1;
    localparam logic [KIND_W-1:0] KIND_M2_F1 = 3'd3;
    localparam logic [KIND_W-1:0] KIND_M2_F2 = 3'd4;

    localparam logic [MODE_W-1:0] MD_EDC = 3'd1;
    localparam logic [MODE_W-1:0] MD_P   = 3'd2;
    localparam logic [MODE_W-1:0] MD_Q   = 3'd3;
    localparam logic [MODE_W-1:0] MD_PQ  = 3'd4;
    localparam logic [MODE_W-1:0] MD_QP  = 3'd5;

    typedef enum logic [1:0] {
        OP_EDC = 2'd0,
        OP_SYN = 2'd1,
        OP_P   = 2'd2,
        OP_Q   = 2'd3
    } sfs_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EDC_PRE,
        ST_SYN,
        ST_PASS1,
        ST_PASS2,
        ST_EDC_POST
    } sfs_state_e;

    typedef struct packed {
        logic              do_edc;
        logic              do_ecc;
        logic              judge_p;
        logic              judge_q;
        logic              q_first;
        logic              two_pass;
        logic [ITER_W-1:0] rounds;
    } sfs_plan_t;

endpackage

// File: rtl/sfs_policy.sv
module sfs_policy
    import sfs_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  logic [MODE_W-1:0] mode,
    input  logic [ITER_W-1:0] rep,
    output sfs_plan_t         plan
);
    logic kind_has_edc;
    logic kind_has_ecc;
    logic mode_edc;
    logic mode_ecc;

    always_comb begin
        kind_has_edc  = (kind == KIND_M1) || (kind == KIND_M2_F1) || (kind == KIND_M2_F2);
        kind_has_ecc  = (kind == KIND_M1) || (kind == KIND_M2_F1);
        mode_edc      = (mode >= MD_EDC) && (mode <= MD_QP);
        mode_ecc      = (mode >= MD_P) && (mode <= MD_QP);

        plan.do_edc   = kind_has_edc && mode_edc;
        plan.do_ecc   = kind_has_ecc && mode_ecc;
        plan.two_pass = (mode == MD_PQ) || (mode == MD_QP);
        plan.q_first  = (mode == MD_Q) || (mode == MD_QP);
        plan.judge_p  = (mode == MD_P) || plan.two_pass;
        plan.judge_q  = (mode == MD_Q) || plan.two_pass;
        if (plan.two_pass && (rep != '0)) begin
            plan.rounds = rep;
        end else begin
            plan.rounds = ITER_W'(1);
        end
    end
endmodule

// File: rtl/sfs_judge.sv
module sfs_judge
    import sfs_pkg::*;
(
    input  sfs_plan_t plan,
    input  logic      p_zero,
    input  logic      q_zero,
    output logic      dirty
);
    always_comb begin
        dirty = (plan.judge_p && !p_zero) || (plan.judge_q && !q_zero);
    end
endmodule

// File: rtl/sfs_launch.sv
module sfs_launch
    import sfs_pkg::*;
(
    input  logic             fire,
    input  sfs_op_e          op,
    output logic [N_OPS-1:0] start_vec
);
    for (genvar i = 0; i < N_OPS; i++) begin : g_op
        assign start_vec[i] = fire && (op == sfs_op_e'(i));
    end
endmodule

// File: rtl/sector_fix_seq.sv
module sector_fix_seq
    import sfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_start,
    input  logic [KIND_W-1:0] sec_kind,
    input  logic              sec_short,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic [ITER_W-1:0] cfg_rounds,
    output logic              edc_start,
    input  logic              edc_done,
    input  logic              edc_match,
    output logic              syn_start,
    input  logic              syn_done,
    input  logic              syn_p_zero,
    input  logic              syn_q_zero,
    output logic              p_start,
    input  logic              p_done,
    output logic              q_start,
    input  logic              q_done,
    output logic              sec_done,
    output logic              err_irq,
    output logic              st_edc_pre_bad,
    output logic              st_edc_post_bad,
    output logic              st_p_syn_nz,
    output logic              st_q_syn_nz,
    output logic              st_ecc_fail
);

    typedef struct packed {
        sfs_state_e        state;
        sfs_plan_t         plan;
        logic [ITER_W-1:0] left;
        sfs_op_e           op;
        logic              fire;
        logic              done;
        logic              irq;
        logic              pre_bad;
        logic              post_bad;
        logic              p_nz;
        logic              q_nz;
        logic              fail;
    } sfs_regs_t;

    sfs_regs_t        reg_d;
    sfs_regs_t        reg_q;
    sfs_plan_t        new_plan;
    logic             syn_dirty;
    logic             pass_done;
    logic [N_OPS-1:0] start_vec;

    sfs_policy u_policy (
        .kind (sec_kind),
        .mode (cfg_mode),
        .rep  (cfg_rounds),
        .plan (new_plan)
    );

    sfs_judge u_judge (
        .plan   (reg_q.plan),
        .p_zero (syn_p_zero),
        .q_zero (syn_q_zero),
        .dirty  (syn_dirty)
    );

    sfs_launch u_launch (
        .fire      (reg_q.fire),
        .op        (reg_q.op),
        .start_vec (start_vec)
    );

    assign pass_done = (reg_q.op == OP_Q) ? q_done : p_done;

    always_comb begin
        reg_d      = reg_q;
        reg_d.fire = 1'b0;
        reg_d.done = 1'b0;
        reg_d.irq  = 1'b0;
        unique case (reg_q.state)
            ST_IDLE: begin
                if (sec_start) begin
                    reg_d.plan     = new_plan;
                    reg_d.left     = new_plan.rounds;
                    reg_d.pre_bad  = 1'b0;
                    reg_d.post_bad = 1'b0;
                    reg_d.p_nz     = 1'b0;
                    reg_d.q_nz     = 1'b0;
                    reg_d.fail     = 1'b0;
                    if (sec_short) begin
                        reg_d.fail = 1'b1;
                        reg_d.irq  = 1'b1;
                        reg_d.done = 1'b1;
                    end else if (new_plan.do_edc) begin
                        reg_d.state = ST_EDC_PRE;
                        reg_d.op    = OP_EDC;
                        reg_d.fire  = 1'b1;
                    end else begin
                        reg_d.done = 1'b1;
                    end
                end
            end
            ST_EDC_PRE: begin
                if (edc_done) begin
                    reg_d.pre_bad = !edc_match;
                    if (reg_q.plan.do_ecc) begin
                        reg_d.state = ST_SYN;
                        reg_d.op    = OP_SYN;
                        reg_d.fire  = 1'b1;
                    end else begin
                        reg_d.state = ST_IDLE;
                        reg_d.done  = 1'b1;
                    end
                end
            end
            ST_SYN: begin
                if (syn_done) begin
                    reg_d.p_nz = !syn_p_zero;
                    reg_d.q_nz = !syn_q_zero;
                    if (syn_dirty && (reg_q.left != '0)) begin
                        reg_d.left  = reg_q.left - ITER_W'(1);
                        reg_d.state = ST_PASS1;
                        reg_d.op    = reg_q.plan.q_first ? OP_Q : OP_P;
                        reg_d.fire  = 1'b1;
                    end else begin
                        reg_d.fail  = syn_dirty;
                        reg_d.state = ST_EDC_POST;
                        reg_d.op    = OP_EDC;
                        reg_d.fire  = 1'b1;
                    end
                end
            end
            ST_PASS1: begin
                if (pass_done) begin
                    reg_d.fire = 1'b1;
                    if (reg_q.plan.two_pass) begin
                        reg_d.state = ST_PASS2;
                        reg_d.op    = reg_q.plan.q_first ? OP_P : OP_Q;
                    end else begin
                        reg_d.state = ST_SYN;
                        reg_d.op    = OP_SYN;
                    end
                end
            end
            ST_PASS2: begin
                if (pass_done) begin
                    reg_d.state = ST_SYN;
                    reg_d.op    = OP_SYN;
                    reg_d.fire  = 1'b1;
                end
            end
            ST_EDC_POST: begin
                if (edc_done) begin
                    reg_d.post_bad = !edc_match;
                    reg_d.done     = 1'b1;
                    reg_d.irq      = reg_q.fail;
                    reg_d.state    = ST_IDLE;
                end
            end
            default: reg_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q       <= '0;
            reg_q.state <= ST_IDLE;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign edc_start       = start_vec[OP_EDC];
    assign syn_start       = start_vec[OP_SYN];
    assign p_start         = start_vec[OP_P];
    assign q_start         = start_vec[OP_Q];
    assign sec_done        = reg_q.done;
    assign err_irq         = reg_q.irq;
    assign st_edc_pre_bad  = reg_q.pre_bad;
    assign st_edc_post_bad = reg_q.post_bad;
    assign st_p_syn_nz     = reg_q.p_nz;
    assign st_q_syn_nz     = reg_q.q_nz;
    assign st_ecc_fail     = reg_q.fail;

    AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_vec)); // R12

    AST_IRQ_WITH_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (sec_done && st_ecc_fail)); // R9

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ecc_fail && !sec_start) |=> st_ecc_fail); // R12

    AST_NO_CORR_WITHOUT_ECC: assert property (@(posedge clk) disable iff (!rst_n)
        (syn_start || p_start || q_start) |-> reg_q.plan.do_ecc); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_done |=> !sec_done); // R12

    AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        sec_done |-> (start_vec == '0)); // R7

endmodule

// File: tb/sector_fix_seq_tb.sv
module sector_fix_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_start = 1'b0;
    logic [2:0] sec_kind = '0;
    logic       sec_short = 1'b0;
    logic [2:0] cfg_mode = '0;
    logic [1:0] cfg_rounds = '0;
    logic       edc_done = 1'b0, edc_match = 1'b0;
    logic       syn_done = 1'b0, syn_p_zero = 1'b0, syn_q_zero = 1'b0;
    logic       p_done = 1'b0, q_done = 1'b0;
    logic       edc_start, syn_start, p_start, q_start;
    logic       sec_done, err_irq;
    logic       st_edc_pre_bad, st_edc_post_bad, st_p_syn_nz, st_q_syn_nz, st_ecc_fail;

    int n_vec = 0;
    int n_bad = 0;
    int exp_ops[$];
    bit e_pre, e_post, e_pnz, e_qnz, e_fail;
    int pn_live, qn_live, edc_cnt;

    always #2.5 clk = ~clk;

    sector_fix_seq u_dut (
        .clk(clk), .rst_n(rst_n), .sec_start(sec_start), .sec_kind(sec_kind),
        .sec_short(sec_short), .cfg_mode(cfg_mode), .cfg_rounds(cfg_rounds),
        .edc_start(edc_start), .edc_done(edc_done), .edc_match(edc_match),
        .syn_start(syn_start), .syn_done(syn_done), .syn_p_zero(syn_p_zero),
        .syn_q_zero(syn_q_zero), .p_start(p_start), .p_done(p_done),
        .q_start(q_start), .q_done(q_done), .sec_done(sec_done), .err_irq(err_irq),
        .st_edc_pre_bad(st_edc_pre_bad), .st_edc_post_bad(st_edc_post_bad),
        .st_p_syn_nz(st_p_syn_nz), .st_q_syn_nz(st_q_syn_nz), .st_ecc_fail(st_ecc_fail)
    );

    function automatic int starts();
        return int'({q_start, p_start, syn_start, edc_start});
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected engine call order and final status, from the requirements.
    task automatic plan_sector(input int kind, input int mode, input int rep, input bit shrt,
                               input int pn, input int qn, input bit pre_ok, input bit post_ok);
        bit edc_k, ecc_k, de, dc, jp, jq, two, qf, bad;
        int rounds, pc, qc;
        exp_ops.delete();
        edc_k  = (kind == 1) || (kind == 3) || (kind == 4);
        ecc_k  = (kind == 1) || (kind == 3);
        de     = !shrt && edc_k && (mode >= 1) && (mode <= 5);
        dc     = !shrt && ecc_k && (mode >= 2) && (mode <= 5);
        two    = (mode == 4) || (mode == 5);
        qf     = (mode == 3) || (mode == 5);
        jp     = (mode == 2) || two;
        jq     = (mode == 3) || two;
        rounds = two ? ((rep == 0) ? 1 : rep) : 1;
        e_pre  = de && !pre_ok;
        e_post = 1'b0; e_pnz = 1'b0; e_qnz = 1'b0; e_fail = shrt;
        if (de) exp_ops.push_back(0);
        if (dc) begin
            pc = pn; qc = qn;
            exp_ops.push_back(1);
            e_pnz = (pc != 0); e_qnz = (qc != 0);
            bad = (jp && e_pnz) || (jq && e_qnz);
            for (int r = 0; r < rounds && bad; r++) begin
                if (qf) begin
                    exp_ops.push_back(3); if (qc > 0) qc--;
                    if (two) begin exp_ops.push_back(2); if (pc > 0) pc--; end
                end else begin
                    exp_ops.push_back(2); if (pc > 0) pc--;
                    if (two) begin exp_ops.push_back(3); if (qc > 0) qc--; end
                end
                exp_ops.push_back(1);
                e_pnz = (pc != 0); e_qnz = (qc != 0);
                bad = (jp && e_pnz) || (jq && e_qnz);
            end
            if (bad) e_fail = 1'b1;
            exp_ops.push_back(0);
            e_post = !post_ok;
        end
    endtask

    task automatic quiet(input string req);
        chk(req, "starts while waiting", starts(), 0);
        chk("R12", "done while busy", int'(sec_done), 0);
    endtask

    task automatic run_sector(input string req, input int kind, input int mode, input int rep,
                              input bit shrt, input int pn, input int qn,
                              input bit pre_ok, input bit post_ok, input int lat);
        int op;
        plan_sector(kind, mode, rep, shrt, pn, qn, pre_ok, post_ok);
        pn_live = pn; qn_live = qn; edc_cnt = 0;
        @(negedge clk);
        sec_kind = 3'(kind); cfg_mode = 3'(mode); cfg_rounds = 2'(rep);
        sec_short = shrt; sec_start = 1'b1;
        forever begin
            @(negedge clk);
            sec_start = 1'b0; edc_done = 1'b0; syn_done = 1'b0; p_done = 1'b0; q_done = 1'b0;
            if (exp_ops.size() == 0) begin
                chk("R12", {req, " done pulse"}, int'(sec_done), 1);
                chk(req, "starts at done", starts(), 0);
                chk("R9", "err_irq", int'(err_irq), int'(e_fail));
                chk("R9", "st_ecc_fail", int'(st_ecc_fail), int'(e_fail));
                chk("R5", "st_edc_pre_bad", int'(st_edc_pre_bad), int'(e_pre));
                chk("R5", "st_edc_post_bad", int'(st_edc_post_bad), int'(e_post));
                chk("R11", "st_p_syn_nz", int'(st_p_syn_nz), int'(e_pnz));
                chk("R11", "st_q_syn_nz", int'(st_q_syn_nz), int'(e_qnz));
                @(negedge clk);
                chk("R12", "done single cycle", int'(sec_done), 0);
                chk("R12", "irq single cycle", int'(err_irq), 0);
                chk("R12", "fail held", int'(st_ecc_fail), int'(e_fail));
                chk("R12", "p_nz held", int'(st_p_syn_nz), int'(e_pnz));
                break;
            end
            op = exp_ops.pop_front();
            chk(req, "engine start", starts(), 1 << op);
            chk("R12", "no done mid-sector", int'(sec_done), 0);
            for (int i = 1; i < lat; i++) begin
                @(negedge clk);
                quiet(req);
            end
            @(negedge clk);
            quiet(req);
            case (op)
                0: begin
                    edc_match = (edc_cnt == 0) ? pre_ok : post_ok;
                    edc_cnt++;
                    edc_done = 1'b1;
                end
                1: begin
                    syn_p_zero = (pn_live == 0);
                    syn_q_zero = (qn_live == 0);
                    syn_done = 1'b1;
                end
                2: begin if (pn_live > 0) pn_live--; p_done = 1'b1; end
                default: begin if (qn_live > 0) qn_live--; q_done = 1'b1; end
            endcase
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R12 watchdog: got 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "starts after reset", starts(), 0);
        chk("R1", "sec_done after reset", int'(sec_done), 0);
        chk("R1", "err_irq after reset", int'(err_irq), 0);
        chk("R1", "status after reset",
            int'({st_edc_pre_bad, st_edc_post_bad, st_p_syn_nz, st_q_syn_nz, st_ecc_fail}), 0);

        //          req    kind mode rep short pn qn pre post lat
        run_sector("R2",  0,   4,   3,  0,    1, 1, 1,  1,   1);
        run_sector("R2",  2,   5,   3,  0,    1, 1, 1,  1,   1);
        run_sector("R2",  6,   2,   1,  0,    1, 1, 1,  1,   1);
        run_sector("R3",  4,   4,   3,  0,    2, 2, 0,  1,   2);
        run_sector("R4",  1,   1,   0,  0,    1, 1, 1,  1,   1);
        run_sector("R4",  1,   0,   0,  0,    1, 1, 1,  1,   1);
        run_sector("R4",  3,   7,   2,  0,    1, 1, 1,  1,   1);
        run_sector("R6",  1,   2,   0,  0,    0, 0, 1,  1,   1);
        run_sector("R6",  1,   2,   0,  0,    0, 3, 1,  1,   2);
        run_sector("R7",  1,   2,   0,  0,    1, 2, 1,  1,   3);
        run_sector("R7",  3,   3,   0,  0,    0, 1, 1,  1,   1);
        run_sector("R8",  1,   4,   3,  0,    2, 1, 1,  1,   2);
        run_sector("R8",  3,   5,   2,  0,    1, 1, 1,  1,   1);
        run_sector("R8",  1,   4,   0,  0,    2, 0, 1,  1,   1);
        run_sector("R9",  1,   5,   3,  0,    5, 1, 0,  0,   2);
        run_sector("R9",  1,   2,   0,  0,    2, 0, 1,  1,   1);
        run_sector("R5",  1,   4,   2,  0,    1, 0, 1,  0,   3);
        run_sector("R10", 1,   4,   3,  1,    1, 1, 1,  1,   1);
        run_sector("R12", 1,   4,   1,  0,    0, 0, 1,  1,   1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule